// File: doc/BRIEF.md
# Serial ADC Conversion Reader

This block is the master end of a serial link to a 10-bit analog-to-digital converter. A single-cycle start request, together with a single-ended/differential select and a 3-bit channel number, launches one read frame. The frame is 24 serial clocks long, which is three byte-sized transfers, and chip select stays active for the whole frame. The outgoing word is padded with leading zeros so that the start bit ends the first byte. The converter's reply then lands byte-aligned: the last ten received bits are the conversion result.

The serial clock comes from a parameterised divider of the system clock. One half-period lasts `DIV_HALF` system cycles, and `DIV_HALF` must exceed the depth of the receive synchroniser. The idle level of the serial clock follows `cpol_i`, so both the low-idle and the high-idle variants of the link are served. In both variants the outgoing bit changes on falling edges and the incoming bit is taken on rising edges. When the frame ends, chip select is released, the result and a null-bit check flag are updated, and a one-cycle done pulse is raised. Chip select then stays idle for at least one full serial clock period before the next frame can begin.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, and whenever reset is applied mid-frame, `cs_n_o` is 1, `busy_o` is 0, `done_o` is 0, `mosi_o` is 0 and `sclk_o` equals `cpol_i`.
- R2: An accepted request produces one frame in which `cs_n_o` goes low once and stays low for exactly 24 rising edges of `sclk_o`.
- R3: The 24 bits on `mosi_o`, taken at the rising edges of `sclk_o` in order, are: seven 0s, a 1 (start bit), `sgl_i`, `chan_i[2]`, `chan_i[1]`, `chan_i[0]`, then twelve 0s.
- R4: While `cs_n_o` is low, `mosi_o` changes only while `sclk_o` is low, and holds steady through every high phase.
- R5: With `cs_n_o` high, `sclk_o` equals `cpol_i`. Inside a frame, each high phase of `sclk_o` lasts exactly `DIV_HALF` system cycles.
- R6: `done_o` is a single-cycle pulse raised in the cycle in which `cs_n_o` returns high. In that cycle, `result_o` holds the `miso_i` bits taken at rising edges 15 to 24, with edge 15 as bit 9.
- R7: `null_err_o` is updated together with `done_o`. It equals the `miso_i` bit taken at rising edge 14, which a well-behaved converter drives as 0.
- R8: `busy_o` is high from the cycle after an accepted request until the block is ready again. A request made while `busy_o` is high is dropped and starts no later frame.
- R9: Between two frames, `cs_n_o` stays high for at least `2*DIV_HALF` system cycles, even with `start_i` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol_i | input | 1 | Serial clock idle level: 0 low, 1 high |
| start_i | input | 1 | Frame request, taken when not busy |
| sgl_i | input | 1 | Single-ended (1) or differential (0) select sent to the converter |
| chan_i | input | 3 | Channel number sent to the converter |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Data to the converter |
| miso_i | input | 1 | Data from the converter, asynchronous |
| result_o | output | 10 | Last conversion result |
| null_err_o | output | 1 | Null bit of the last frame was not 0 |
| done_o | output | 1 | One-cycle pulse at frame end |

## Verification
Frames run in both clock polarities. They use several channel and select codes, so each header bit can be told apart from its neighbours, and position or order errors in the start bit or channel field show up. The converter replies mix all-zero, all-one and alternating results with a set or clear null bit. This separates off-by-one errors in the reply window from mix-ups between the null bit and result bit 9. Directed cases cover a request made mid-frame, a request held high across the frame end, and reset applied mid-frame.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    localparam int FRAME_BITS = 24;
    localparam int RES_W      = 10;
    localparam int CH_W       = 3;
    localparam int BITN_W     = $clog2(FRAME_BITS);
    localparam int NULL_POS   = RES_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP1,
        ST_GAP2
    } seq_state_e;

    typedef struct packed {
        seq_state_e              st;
        logic [BITN_W-1:0]       bitn;
        logic [FRAME_BITS-1:0]   tx;
        logic [FRAME_BITS-1:0]   rx;
        logic [RES_W-1:0]        res;
        logic                    nerr;
        logic                    done;
    } seq_regs_t;

    // Header: zero padding, start bit, mode bit, channel, zero padding to 24 bits.
    function automatic logic [FRAME_BITS-1:0] build_tx_word(input logic sgl,
                                                           input logic [CH_W-1:0] ch);
        logic [FRAME_BITS-1:0] w;
        w = '0;
        w[FRAME_BITS-8]  = 1'b1;
        w[FRAME_BITS-9]  = sgl;
        w[FRAME_BITS-10] = ch[2];
        w[FRAME_BITS-11] = ch[1];
        w[FRAME_BITS-12] = ch[0];
        return w;
    endfunction

endpackage

// File: rtl/adcrd_halfper.sv
module adcrd_halfper #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == LAST);
        cnt_d = cnt_q;
        if (clr || tick) cnt_d = '0;
        else             cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt_q == '0)); // R5
endmodule

// File: rtl/adcrd_sync2.sv
module adcrd_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adcrd_pkg::*;
#(
    parameter int DIV_HALF    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpol_i,
    input  logic              start_i,
    input  logic              sgl_i,
    input  logic [CH_W-1:0]   chan_i,
    output logic              busy_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [RES_W-1:0]  result_o,
    output logic              null_err_o,
    output logic              done_o
);
    localparam logic [BITN_W-1:0] LAST_BIT = BITN_W'(FRAME_BITS - 1);
    localparam int GAP_MIN = 2 * DIV_HALF;
    localparam int GAP_W   = $clog2(GAP_MIN + 2);

    seq_regs_t r_d, r_q;
    logic      tick;
    logic      miso_s;
    logic      in_frame;

    adcrd_halfper #(.DIV_HALF(DIV_HALF)) u_halfper (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (r_q.st == ST_IDLE),
        .tick  (tick)
    );

    adcrd_sync2 #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (miso_i),
        .q     (miso_s)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_LOW;
                    r_d.bitn = '0;
                    r_d.tx   = build_tx_word(sgl_i, chan_i);
                end
            end
            ST_LOW: begin
                if (tick) begin
                    r_d.st = ST_HIGH;
                    r_d.rx = {r_q.rx[FRAME_BITS-2:0], miso_s};
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    if (r_q.bitn == LAST_BIT) begin
                        r_d.st   = ST_GAP1;
                        r_d.done = 1'b1;
                        r_d.res  = r_q.rx[RES_W-1:0];
                        r_d.nerr = r_q.rx[NULL_POS];
                        r_d.tx   = '0;
                    end else begin
                        r_d.st   = ST_LOW;
                        r_d.bitn = r_q.bitn + 1'b1;
                        r_d.tx   = {r_q.tx[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end
            ST_GAP1: if (tick) r_d.st = ST_GAP2;
            ST_GAP2: if (tick) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_frame   = (r_q.st == ST_LOW) || (r_q.st == ST_HIGH);
    assign cs_n_o     = !in_frame;
    assign sclk_o     = in_frame ? (r_q.st == ST_HIGH) : cpol_i;
    assign mosi_o     = r_q.tx[FRAME_BITS-1];
    assign busy_o     = (r_q.st != ST_IDLE);
    assign done_o     = r_q.done;
    assign result_o   = r_q.res;
    assign null_err_o = r_q.nerr;

    // ---------------- assertions ----------------
    logic              chk_sclk_prev;
    logic [BITN_W:0]   chk_rises_q;
    logic [GAP_W-1:0]  chk_gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_sclk_prev <= 1'b0;
            chk_rises_q   <= '0;
            chk_gap_q     <= GAP_W'(GAP_MIN);
        end else begin
            chk_sclk_prev <= sclk_o;
            if (cs_n_o) chk_rises_q <= '0;
            else if (sclk_o && !chk_sclk_prev) chk_rises_q <= chk_rises_q + 1'b1;
            if (!cs_n_o) chk_gap_q <= '0;
            else if (chk_gap_q < GAP_W'(GAP_MIN)) chk_gap_q <= chk_gap_q + 1'b1;
        end
    end

    AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (chk_rises_q == (BITN_W+1)'(FRAME_BITS))); // R2
    AST_MOSI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && sclk_o && $past(sclk_o) && !$past(cs_n_o)) |-> $stable(mosi_o)); // R4
    AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $rose(cs_n_o)); // R6
    AST_GAP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> (chk_gap_q >= GAP_W'(GAP_MIN))); // R9
    AST_IDLE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o); // R8
endmodule

// File: tb/adc_frame_reader_bench.sv
module adc_frame_reader_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 4;
    localparam int NVEC       = 6;

    // {cpol, sgl, chan[2:0], reply[23:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 3'd0, 24'h000155},
        {1'b1, 1'b1, 3'd5, 24'hABC3FF},
        {1'b0, 1'b0, 3'd7, 24'h000000},
        {1'b1, 1'b0, 3'd2, 24'h000600},
        {1'b0, 1'b1, 3'd3, 24'hFFF400},
        {1'b1, 1'b1, 3'd6, 24'h55A2AA}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpol_i = 1'b0, start_i = 1'b0, sgl_i = 1'b0, miso_i = 1'b0;
    logic [2:0] chan_i = 3'd0;
    logic busy_o, cs_n_o, sclk_o, mosi_o, null_err_o, done_o;
    logic [9:0] result_o;

    int checks = 0, fails = 0, cyc = 0;
    int rises = 0, hi_run = 0, frames = 0, cs_hi_run = 0, last_gap = 0;
    logic [23:0] txcap = '0, reply_cur = '0;
    logic prev_sclk = 1'b0, prev_cs = 1'b1, prev_mosi = 1'b0;
    logic mosi_bad = 1'b0, width_bad = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_frame_reader #(.DIV_HALF(DIV_HALF)) u_adc_frame_reader (
        .clk(clk), .rst_n(rst_n), .cpol_i(cpol_i), .start_i(start_i),
        .sgl_i(sgl_i), .chan_i(chan_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
        .result_o(result_o), .null_err_o(null_err_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Converter model and link monitor, all at the falling system edge.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
        if (!cs_n_o && prev_cs) begin
            frames++;
            last_gap = cs_hi_run;
            rises = 0;
            txcap = '0;
            hi_run = 0;
            miso_i = reply_cur[23];
        end
        if (cs_n_o) cs_hi_run++;
        else        cs_hi_run = 0;
        if (!cs_n_o && sclk_o && !prev_sclk) begin
            rises++;
            txcap = {txcap[22:0], mosi_o};
            hi_run = 1;
            prev_mosi = mosi_o;
        end else if (!cs_n_o && sclk_o && prev_sclk) begin
            hi_run++;
            if (mosi_o != prev_mosi) mosi_bad = 1'b1;
        end
        if (!cs_n_o && !sclk_o && prev_sclk && rises > 0) begin
            if (hi_run != DIV_HALF) width_bad = 1'b1;
            if (rises < 24) miso_i = reply_cur[5'(23 - rises)];
        end
        prev_sclk = sclk_o;
        prev_cs = cs_n_o;
    end

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic run_frame(input logic cp, input logic sg, input logic [2:0] ch,
                             input logic [23:0] reply);
        bit seen;
        logic [23:0] exp_tx;
        exp_tx = {7'b0, 1'b1, sg, ch, 12'b0};
        @(negedge clk);
        cpol_i = cp;
        reply_cur = reply;
        mosi_bad = 1'b0;
        width_bad = 1'b0;
        @(negedge clk);
        check(sclk_o == cp && cs_n_o, "R5 idle sclk level", {31'b0, sclk_o}, {31'b0, cp});
        sgl_i = sg;
        chan_i = ch;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && !cs_n_o, "R8 busy after request", {31'b0, busy_o}, 32'd1);
        wait_done(seen);
        check(seen, "R6 done seen", {31'b0, seen}, 32'd1);
        check(cs_n_o, "R6 cs high with done", {31'b0, cs_n_o}, 32'd1);
        check(rises == 24, "R2 rising edge count", rises, 32'd24);
        check(txcap == exp_tx, "R3 header bits", {8'b0, txcap}, {8'b0, exp_tx});
        check(!mosi_bad, "R4 mosi steady while high", {31'b0, mosi_bad}, 32'd0);
        check(!width_bad, "R5 high phase width", {31'b0, width_bad}, 32'd0);
        check(result_o == reply[9:0], "R6 result", {22'b0, result_o}, {22'b0, reply[9:0]});
        check(null_err_o == reply[10], "R7 null flag", {31'b0, null_err_o}, {31'b0, reply[10]});
        @(negedge clk);
        check(!done_o, "R6 done single cycle", {31'b0, done_o}, 32'd0);
        for (int i = 0; i < 3 * DIV_HALF; i++) @(negedge clk);
    endtask

    initial begin
        bit seen;
        int f0;
        repeat (3) @(negedge clk);
        // R1: state held in reset and right after release
        check(cs_n_o && !busy_o && !done_o && !mosi_o && sclk_o == cpol_i,
              "R1 reset outputs", {28'b0, cs_n_o, busy_o, done_o, mosi_o}, 32'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n_o && !busy_o && !done_o && !mosi_o, "R1 after release",
              {28'b0, cs_n_o, busy_o, done_o, mosi_o}, 32'h8);

        for (int v = 0; v < NVEC; v++)
            run_frame(VEC[v][28], VEC[v][27], VEC[v][26:24], VEC[v][23:0]);

        // R8: request during a frame is dropped
        f0 = frames;
        cpol_i = 1'b0;
        reply_cur = 24'h000001;
        sgl_i = 1'b1; chan_i = 3'd1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        check(busy_o, "R8 busy mid-frame", {31'b0, busy_o}, 32'd1);
        sgl_i = 1'b0; chan_i = 3'd6; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done(seen);
        check(txcap == {7'b0, 1'b1, 1'b1, 3'd1, 12'b0}, "R8 first header kept",
              {8'b0, txcap}, {8'b0, 7'b0, 1'b1, 1'b1, 3'd1, 12'b0});
        repeat (300) @(negedge clk);
        check(frames == f0 + 1, "R8 no extra frame", frames - f0, 32'd1);

        // R9: request held high across frame end
        f0 = frames;
        sgl_i = 1'b1; chan_i = 3'd2; start_i = 1'b1;
        wait_done(seen);
        for (int i = 0; i < 100 && frames == f0 + 1; i++) @(negedge clk);
        start_i = 1'b0;
        check(frames == f0 + 2, "R9 second frame started", frames - f0, 32'd2);
        check(last_gap >= 2 * DIV_HALF, "R9 cs idle gap", last_gap, 2 * DIV_HALF);
        wait_done(seen);
        repeat (3 * DIV_HALF) @(negedge clk);

        // R1: reset mid-frame
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(cs_n_o && !busy_o && !mosi_o && sclk_o == cpol_i, "R1 reset mid-frame",
              {29'b0, cs_n_o, busy_o, mosi_o}, 32'h4);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule